// File: doc/BRIEF.md
# PC Card Socket Status Controller

This block looks after a single PC Card socket. Every asynchronous status line coming from the card goes through a two-flop synchronizer and then a stability filter. The write-protect, ready and both voltage-sense lines use a short filter. The two card-detect lines use a much longer one, so that the bounce of an insertion is absorbed. A card counts as present only when both filtered detect lines are low. Changes of write protect, ready and card presence are latched as interrupt causes, and each cause can be masked.

Software uses a small write/read register port to set the power enables, the card reset and the attribute-memory select. When no card is present, the controller forces power off and holds the card in reset, whatever the software bits say. A combinational decoder turns a chip select into the two active-low byte-lane card enables. It uses the configured bus width, the access size and the low address bit.

Registers are at `reg_addr`. 0 is CTRL (read/write). 1 is STATUS (read only). 2 is PEND (write 1 to clear). 3 is MASK. Writes take effect at the clock edge where `reg_we` is high. Reads are combinational.

Top module: `pcsock_ctrl`

## Requirements
- R1: After reset the following hold: CTRL reads 0x08, STATUS reads 0x6F, PEND and MASK read 0, `irq` and all three power enables are low, and `card_rst` is high. The fields are CTRL bit0 3.3 V enable, bit1 5 V enable, bit2 VPP enable, bit3 card reset, bit4 attribute select. STATUS bit0 is write protect, bit1 ready, bit2 VS1, bit3 VS2, bit4 card present, bit5 filtered CD1, bit6 filtered CD2.
- R2: A write-protect, ready or voltage-sense level is taken into STATUS only after it has stayed stable for SHORT_CYC cycles after synchronization. A pulse of fewer cycles leaves STATUS and PEND unchanged.
- R3: A card-detect level is taken in only after it has stayed stable for LONG_CYC cycles. A shorter pulse leaves presence unchanged.
- R4: Card present (STATUS bit4) is high only when both filtered card-detect lines are low.
- R5: Each change of filtered write protect sets PEND bit0, each change of ready sets bit1, and each change of card present sets bit2. Writing 1 to a PEND bit clears it. If a set and a clear happen in the same cycle, the set wins.
- R6: `irq` is high exactly when some PEND bit is set and its MASK bit (same position) is set.
- R7: `pwr3v_en`, `pwr5v_en` and `vpp_en` follow their CTRL bits while a card is present, and are low whenever none is.
- R8: While no card is present, `card_rst` is high and CTRL bit3 is forced to 1. While a card is present, `card_rst` follows CTRL bit3.
- R9: `attr_sel` follows CTRL bit4 regardless of card presence.
- R10: With `wide_bus` low (1-byte bus), `ce1_n` equals `cs_n`, `ce2_n` stays high and `card_a0` equals `addr0`.
- R11: With `wide_bus` high (2-byte bus), `card_a0` is 0. A byte access (`half_acc` low) at even `addr0` drives only `ce1_n` from `cs_n`, and one at odd `addr0` drives only `ce2_n` from `cs_n`. A half-word access (`half_acc` high) drives both from `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Card write-protect status (async) |
| rdy_i | input | 1 | Card ready status (async) |
| vs1_n_i | input | 1 | Voltage sense 1 (async) |
| vs2_n_i | input | 1 | Voltage sense 2 (async) |
| cd1_n_i | input | 1 | Card detect 1, active low (async) |
| cd2_n_i | input | 1 | Card detect 2, active low (async) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Socket interrupt |
| pwr3v_en | output | 1 | 3.3 V VCC enable |
| pwr5v_en | output | 1 | 5 V VCC enable |
| vpp_en | output | 1 | VPP enable |
| card_rst | output | 1 | Card reset |
| attr_sel | output | 1 | Attribute-memory select (high = attribute space) |
| cs_n | input | 1 | Chip select for the card region, active low |
| wide_bus | input | 1 | 1 = 2-byte card bus, 0 = 1-byte |
| half_acc | input | 1 | 1 = half-word access, 0 = byte access |
| addr0 | input | 1 | Lowest address bit of the access |
| ce1_n | output | 1 | Card enable, low byte lane |
| ce2_n | output | 1 | Card enable, high byte lane |
| card_a0 | output | 1 | Lowest address bit presented to the card |

## Verification
The bench drives glitches shorter than each filter length on write protect and on one card-detect line. A filter that accepted levels too early would show a status change or a spurious PEND bit there. It inserts the card one detect pin at a time. A design that ORed the lines instead of requiring both would report presence after the first pin. It writes a reset-release and power-on pattern while the socket is empty, then removes the card while powered. Missing gating or a missing forced-reset bit appears on the power pins and in the CTRL readback. All byte-lane cases are driven on both bus widths, with chip select idle as well, which catches a swapped lane or a leaked address bit.

// File: rtl/pcsock_pkg.sv
package pcsock_pkg;

    localparam int NUM_STAT  = 6;
    localparam int NUM_CAUSE = 3;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_PEND   = 2'd2;
    localparam logic [1:0] ADDR_MASK   = 2'd3;

    // status line indices (short filter below IDX_CD1)
    localparam int IDX_WP  = 0;
    localparam int IDX_RDY = 1;
    localparam int IDX_VS1 = 2;
    localparam int IDX_VS2 = 3;
    localparam int IDX_CD1 = 4;
    localparam int IDX_CD2 = 5;

    typedef struct packed {
        logic attr;
        logic rst;
        logic vpp;
        logic en5;
        logic en3;
    } ctrl_t;

endpackage

// File: rtl/pcsock_filt.sv
module pcsock_filt #(
    parameter int  LEN     = 12,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          out;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.out) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(LEN - 1)) begin
            st_d.out = st_q.s2;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL, out: RST_VAL, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.out;
endmodule

// File: rtl/pcsock_lane.sv
module pcsock_lane (
    input  logic cs_n,
    input  logic wide_bus,
    input  logic half_acc,
    input  logic addr0,
    output logic ce1_n,
    output logic ce2_n,
    output logic card_a0
);
    always_comb begin
        ce1_n   = 1'b1;
        ce2_n   = 1'b1;
        card_a0 = 1'b0;
        if (!wide_bus) begin
            ce1_n   = cs_n;
            card_a0 = addr0;
        end else if (half_acc) begin
            ce1_n = cs_n;
            ce2_n = cs_n;
        end else if (addr0) begin
            ce2_n = cs_n;
        end else begin
            ce1_n = cs_n;
        end
    end
endmodule

// File: rtl/pcsock_ctrl.sv
module pcsock_ctrl
    import pcsock_pkg::*;
#(
    parameter int SHORT_CYC = 12,
    parameter int LONG_CYC  = 200000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_i,
    input  logic       rdy_i,
    input  logic       vs1_n_i,
    input  logic       vs2_n_i,
    input  logic       cd1_n_i,
    input  logic       cd2_n_i,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       pwr3v_en,
    output logic       pwr5v_en,
    output logic       vpp_en,
    output logic       card_rst,
    output logic       attr_sel,
    input  logic       cs_n,
    input  logic       wide_bus,
    input  logic       half_acc,
    input  logic       addr0,
    output logic       ce1_n,
    output logic       ce2_n,
    output logic       card_a0
);
    typedef struct packed {
        ctrl_t                ctrl;
        logic [NUM_CAUSE-1:0] pend;
        logic [NUM_CAUSE-1:0] mask;
        logic                 wp_p;
        logic                 rdy_p;
        logic                 pres_p;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_STAT-1:0] raw, filt;
    logic                present;
    logic [NUM_CAUSE-1:0] cause;

    assign raw = {cd2_n_i, cd1_n_i, vs2_n_i, vs1_n_i, rdy_i, wp_i};

    for (genvar i = 0; i < NUM_STAT; i++) begin : g_filt
        localparam int FLEN = (i >= IDX_CD1) ? LONG_CYC : SHORT_CYC;
        pcsock_filt #(.LEN(FLEN), .RST_VAL(1'b1)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[i]),
            .dout (filt[i])
        );
    end

    assign present = ~(filt[IDX_CD1] | filt[IDX_CD2]);
    assign cause   = {present != st_q.pres_p,
                      filt[IDX_RDY] != st_q.rdy_p,
                      filt[IDX_WP] != st_q.wp_p};

    always_comb begin
        st_d        = st_q;
        st_d.wp_p   = filt[IDX_WP];
        st_d.rdy_p  = filt[IDX_RDY];
        st_d.pres_p = present;
        if (reg_we) begin
            case (reg_addr)
                ADDR_CTRL: st_d.ctrl = ctrl_t'(reg_wdata[4:0]);
                ADDR_PEND: st_d.pend = st_q.pend & ~reg_wdata[NUM_CAUSE-1:0];
                ADDR_MASK: st_d.mask = reg_wdata[NUM_CAUSE-1:0];
                default: ;
            endcase
        end
        st_d.pend = st_d.pend | cause;
        if (!present) begin
            st_d.ctrl.rst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: '{attr: 1'b0, rst: 1'b1, vpp: 1'b0, en5: 1'b0, en3: 1'b0},
                      pend: '0, mask: '0, wp_p: 1'b1, rdy_p: 1'b1, pres_p: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:   reg_rdata = {3'b000, st_q.ctrl};
            ADDR_STATUS: reg_rdata = {1'b0, filt[IDX_CD2], filt[IDX_CD1], present,
                                      filt[IDX_VS2], filt[IDX_VS1], filt[IDX_RDY], filt[IDX_WP]};
            ADDR_PEND:   reg_rdata = {{(8-NUM_CAUSE){1'b0}}, st_q.pend};
            default:     reg_rdata = {{(8-NUM_CAUSE){1'b0}}, st_q.mask};
        endcase
    end

    assign irq      = |(st_q.pend & st_q.mask);
    assign pwr3v_en = st_q.ctrl.en3 & present;
    assign pwr5v_en = st_q.ctrl.en5 & present;
    assign vpp_en   = st_q.ctrl.vpp & present;
    assign card_rst = st_q.ctrl.rst | ~present;
    assign attr_sel = st_q.ctrl.attr;

    pcsock_lane u_lane (
        .cs_n    (cs_n),
        .wide_bus(wide_bus),
        .half_acc(half_acc),
        .addr0   (addr0),
        .ce1_n   (ce1_n),
        .ce2_n   (ce2_n),
        .card_a0 (card_a0)
    );
endmodule

// File: rtl/pcsock_chk.sv
module pcsock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       present,
    input logic       wp_f,
    input logic       rdy_f,
    input logic [2:0] pend,
    input logic       irq,
    input logic       pwr3v_en,
    input logic       pwr5v_en,
    input logic       vpp_en,
    input logic       card_rst,
    input logic       cs_n,
    input logic       wide_bus,
    input logic       ce1_n,
    input logic       ce2_n
);
    p_pwr_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !present |-> (!pwr3v_en && !pwr5v_en && !vpp_en));

    p_rst_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !present |-> card_rst);

    p_wp_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wp_f) |=> pend[0]);

    p_rdy_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdy_f) |=> pend[1]);

    p_pres_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(present) |=> pend[2]);

    p_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == 3'b000) |-> !irq);

    p_narrow_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_bus |-> ce2_n);

    p_cs_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (ce1_n && ce2_n));
endmodule

bind pcsock_ctrl pcsock_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .present (present),
    .wp_f    (filt[0]),
    .rdy_f   (filt[1]),
    .pend    (st_q.pend),
    .irq     (irq),
    .pwr3v_en(pwr3v_en),
    .pwr5v_en(pwr5v_en),
    .vpp_en  (vpp_en),
    .card_rst(card_rst),
    .cs_n    (cs_n),
    .wide_bus(wide_bus),
    .ce1_n   (ce1_n),
    .ce2_n   (ce2_n)
);

// File: tb/tb_pcsock_ctrl.sv
module tb_pcsock_ctrl;
    localparam int SHORT = 4;
    localparam int LONG  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_i = 1, rdy_i = 1, vs1_n_i = 1, vs2_n_i = 1, cd1_n_i = 1, cd2_n_i = 1;
    logic reg_we = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic irq, pwr3v_en, pwr5v_en, vpp_en, card_rst, attr_sel;
    logic cs_n = 1, wide_bus = 0, half_acc = 0, addr0 = 0;
    logic ce1_n, ce2_n, card_a0;

    always #2.5 clk = ~clk;

    pcsock_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut (.*);

    typedef struct {
        logic [16:0] exp;
        logic [16:0] msk;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [16:0] obs;
    assign obs = {irq, pwr3v_en, pwr5v_en, vpp_en, card_rst, attr_sel,
                  ce1_n, ce2_n, card_a0, reg_rdata};

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if ((obs & it.msk) !== (it.exp & it.msk)) begin
                fails++;
                $display("FAIL %s: actual %h expected %h (mask %h)",
                         it.req, obs & it.msk, it.exp & it.msk, it.msk);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 0;
    endtask

    task automatic chk_reg(logic [1:0] a, logic [7:0] e, string req);
        reg_addr = a;
        q.push_back('{exp: {9'h0, e}, msk: 17'h000FF, req: req});
        step();
    endtask

    // pins {irq,en3,en5,vpp,rst,attr,ce1,ce2,a0}
    task automatic chk_pin(logic [8:0] e, string req);
        q.push_back('{exp: {e, 8'h0}, msk: 17'h1FF00, req: req});
        step();
    endtask

    task automatic chk_lane(logic c1, logic c2, logic a, string req);
        q.push_back('{exp: {6'h0, c1, c2, a, 8'h0}, msk: 17'h00700, req: req});
        step();
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        step(5);
        rst_n = 1;
        step(2);
        // R1 reset state
        chk_reg(2'd0, 8'h08, "R1 ctrl");
        chk_reg(2'd1, 8'h6F, "R1 status");
        chk_reg(2'd2, 8'h00, "R1 pend");
        chk_reg(2'd3, 8'h00, "R1 mask");
        chk_pin(9'h016, "R1 pins");

        // software enables while empty: R7 gating, R8 forced reset, R9 attr
        wr(2'd0, 8'h17);
        chk_reg(2'd0, 8'h1F, "R8 forced rst bit");
        chk_pin(9'h01E, "R7 power gated R9 attr");
        wr(2'd3, 8'h07);

        // one detect pin only: R4
        cd1_n_i = 0;
        step(LONG + 10);
        chk_reg(2'd1, 8'h4F, "R4 one pin not present");
        chk_pin(9'h01E, "R4 no irq");

        // both pins: present, R5/R6 irq
        cd2_n_i = 0;
        step(LONG + 10);
        chk_reg(2'd1, 8'h1F, "R4 present");
        chk_reg(2'd2, 8'h04, "R5 pres cause");
        chk_pin(9'h1FE, "R6 irq R7 power on");
        wr(2'd2, 8'h04);
        chk_reg(2'd2, 8'h00, "R5 w1c");
        chk_pin(9'h0FE, "R6 irq low");

        wr(2'd0, 8'h05);
        chk_pin(9'h0A6, "R8 rst follows R7 R9");

        // R2 short glitch on wp
        wp_i = 0; step(2); wp_i = 1;
        step(SHORT + 10);
        chk_reg(2'd1, 8'h1F, "R2 glitch ignored");
        chk_reg(2'd2, 8'h00, "R2 no cause");

        // R2 held level
        wp_i = 0;
        step(SHORT + 10);
        chk_reg(2'd1, 8'h1E, "R2 wp accepted");
        chk_reg(2'd2, 8'h01, "R5 wp cause");
        chk_pin(9'h1A6, "R6 irq wp");
        wr(2'd2, 8'h01);

        // R6 masked cause
        wr(2'd3, 8'h05);
        rdy_i = 0;
        step(SHORT + 10);
        chk_reg(2'd1, 8'h1C, "R2 rdy accepted");
        chk_reg(2'd2, 8'h02, "R5 rdy cause");
        chk_pin(9'h0A6, "R6 masked");
        wr(2'd3, 8'h07);
        chk_pin(9'h1A6, "R6 unmasked");
        wr(2'd2, 8'h02);
        chk_pin(9'h0A6, "R6 cleared");

        // lanes R10 / R11
        cs_n = 0; wide_bus = 0; half_acc = 0; addr0 = 1;
        chk_lane(0, 1, 1, "R10 narrow odd");
        half_acc = 1; addr0 = 0;
        chk_lane(0, 1, 0, "R10 narrow half");
        wide_bus = 1; half_acc = 0; addr0 = 0;
        chk_lane(0, 1, 0, "R11 even byte");
        addr0 = 1;
        chk_lane(1, 0, 0, "R11 odd byte");
        half_acc = 1;
        chk_lane(0, 0, 0, "R11 half word");
        cs_n = 1;
        chk_lane(1, 1, 0, "R11 cs idle");
        wide_bus = 0; half_acc = 0; addr0 = 0;

        // R3 short detect glitch
        cd1_n_i = 1; step(10); cd1_n_i = 0;
        step(LONG + 20);
        chk_reg(2'd1, 8'h1C, "R3 glitch ignored");
        chk_reg(2'd2, 8'h00, "R3 no cause");

        // removal
        cd1_n_i = 1;
        step(LONG + 20);
        chk_reg(2'd1, 8'h2C, "R3 removed");
        chk_reg(2'd0, 8'h0D, "R8 rst bit set on removal");
        chk_pin(9'h116, "R7 power down R8 rst");

        step(3);
        done = 1;
        summary();
    end
endmodule